// File: doc/BRIEF.md
# XMODEM Checksum Block Receiver

This block runs the receiving side of the XMODEM checksum protocol. It sits behind a byte-wide serial receiver and takes bytes from it over a valid/ready stream. It also watches a receive-overrun flag. Toward the serial transmitter it raises one-byte requests for the ACK and NAK handshake characters. Toward a destination memory it drives an address/data write strobe.

A pulse on `start` sends a NAK, which tells the sender the receiver is ready. The block then expects block 1. Each frame has a fixed layout: a start-of-header byte, the block number, the complement of the block number, 128 payload bytes, and an additive checksum. Payload bytes go straight to memory at consecutive addresses, beginning at a base address set by a parameter.

When a frame fails its checksum, the block moves the write pointer back to the start of that block and asks for the block again. Any other framing fault ends the transfer, as does an overrun or too many retries. A status code gives the outcome, and a one-cycle done pulse marks the moment that code becomes final.

Top module: `xmdm_block_rx`

## Requirements
- R1: A `start` pulse clears the block number to 1, the bad-frame count to 0 and the write pointer to BASE_ADDR (default 0x8000). It sets status to BUSY (1) and then requests the byte NAK (0x15).
- R2: The first byte of a frame must be SOH (0x01). If the first byte is EOT (0x04), the block answers with ACK (0x06), and once that ACK is taken the status becomes DONE (2).
- R3: The byte after SOH must equal the expected block number, and the byte after that must equal its bitwise complement. Any other header, number or complement byte ends the transfer with status FRAME_ABORT (4) and causes no memory write.
- R4: Exactly 128 payload bytes follow. Each one is written, in the cycle it is accepted, to the next consecutive address.
- R5: The checksum byte is compared with the 8-bit sum (modulo 256) of the payload. On a match the block requests ACK, increments the expected block number and clears the bad-frame count.
- R6: On a checksum mismatch the block requests NAK and moves the write pointer back by 128, so that the resent block overwrites the same addresses. It also increments the bad-frame count.
- R7: When the bad-frame count reaches 9 for one block, the final NAK is still issued. Once it is taken the status becomes RETRY_ABORT (3).
- R8: A receive overrun while BUSY ends the transfer at the next edge with status OVERRUN_ABORT (5). A byte offered in that same cycle is neither accepted nor written.
- R9: A handshake byte stays on `tx_data` with `tx_valid` high until `tx_ready` takes it. While it waits, `rx_ready` stays low.
- R10: `done` is high for exactly one cycle, in the cycle the final status (2 to 5) first appears.
- R11: The expected block number wraps from 255 to 0.
- R12: `start` restarts the engine from any state, including partway through a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin or restart a transfer |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts a byte this cycle |
| rx_overrun | input | 1 | Receiver lost a byte |
| tx_valid | output | 1 | Handshake byte requested |
| tx_data | output | 8 | Handshake byte (ACK or NAK) |
| tx_ready | input | 1 | Transmitter takes the byte |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Memory write address |
| wr_data | output | 8 | Memory write data |
| status | output | 3 | 0 idle, 1 busy, 2 done, 3 retry abort, 4 frame abort, 5 overrun abort |
| done | output | 1 | One-cycle pulse when the status becomes final |

## Verification
Two events can fall on the same edge: accepting a payload byte and reacting to an overrun. The bench offers a payload byte with `rx_valid` high in the same cycle that it raises `rx_overrun`. It then expects no write for that byte, the overrun abort code and exactly one done pulse. A similar collision is provoked between `start` and a frame that is still in flight. There the judge is that the next write lands again at the base address, under block number 1.

// File: rtl/xmdm_pkg.sv
`timescale 1ns/1ps
package xmdm_pkg;
   localparam logic [7:0] C_SOH = 8'h01;
   localparam logic [7:0] C_EOT = 8'h04;
   localparam logic [7:0] C_ACK = 8'h06;
   localparam logic [7:0] C_NAK = 8'h15;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_BUSY      = 3'd1,
      ST_DONE      = 3'd2,
      ST_ABT_RETRY = 3'd3,
      ST_ABT_FRAME = 3'd4,
      ST_ABT_OVR   = 3'd5
   } xfer_stat_t;

   typedef enum logic [2:0] {
      PH_IDLE, PH_TX, PH_HDR, PH_BNUM, PH_BCPL, PH_DATA, PH_CSUM
   } phase_t;
endpackage

// File: rtl/xmdm_sum.sv
`timescale 1ns/1ps
module xmdm_sum #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          add,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] sum
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sum <= '0;
      else if (clr) sum <= '0;
      else if (add) sum <= sum + din;
   end
endmodule

// File: rtl/xmdm_addr.sv
`timescale 1ns/1ps
module xmdm_addr #(
   parameter int AW        = 16,
   parameter int BASE_ADDR = 'h8000,
   parameter int BLK_LEN   = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          inc,
   input  logic          rewind,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] BASE_V = AW'(BASE_ADDR);
   localparam logic [AW-1:0] STEP_V = AW'(BLK_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr <= BASE_V;
      else if (load)    addr <= BASE_V;
      else if (rewind)  addr <= addr - STEP_V;
      else if (inc)     addr <= addr + 1'b1;
   end
endmodule

// File: rtl/xmdm_retry.sv
`timescale 1ns/1ps
module xmdm_retry #(
   parameter int MAX_BAD = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int BW = $clog2(MAX_BAD + 1);

   generate
      if (MAX_BAD == 1) begin : g_single
         assign last = 1'b1;
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ clr ^ inc;
      end else begin : g_count
         logic [BW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (clr)  cnt <= '0;
            else if (inc)  cnt <= cnt + 1'b1;
         end
         assign last = (cnt == BW'(MAX_BAD - 1));
      end
   endgenerate
endmodule

// File: rtl/xmdm_ctrl.sv
`timescale 1ns/1ps
module xmdm_ctrl
   import xmdm_pkg::*;
#(
   parameter int BLK_LEN = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic       rx_overrun,
   input  logic       tx_ready,
   input  logic [7:0] sum,
   input  logic       retry_last,
   output logic       rx_ready,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   output logic       wr_en,
   output logic       sum_clr,
   output logic       addr_load,
   output logic       addr_rewind,
   output logic       bad_clr,
   output logic       bad_inc,
   output logic [2:0] status,
   output logic       done
);
   localparam int CW = $clog2(BLK_LEN);
   localparam logic [CW-1:0] LAST_IDX = CW'(BLK_LEN - 1);

   phase_t     phase;
   xfer_stat_t stat_q, final_q;
   logic [7:0] blk_q, txb_q;
   logic [CW-1:0] cnt_q;
   logic       done_q;
   logic       accept, sum_ok;

   assign rx_ready = (phase == PH_HDR)  || (phase == PH_BNUM) || (phase == PH_BCPL) ||
                     (phase == PH_DATA) || (phase == PH_CSUM);
   assign accept   = rx_valid && rx_ready && !rx_overrun && !start;
   assign sum_ok   = (rx_data == sum);

   assign tx_valid    = (phase == PH_TX);
   assign tx_data     = txb_q;
   assign wr_en       = accept && (phase == PH_DATA);
   assign sum_clr     = start || (accept && phase == PH_BCPL);
   assign addr_load   = start;
   assign addr_rewind = accept && (phase == PH_CSUM) && !sum_ok;
   assign bad_inc     = addr_rewind;
   assign bad_clr     = start || (accept && phase == PH_CSUM && sum_ok);
   assign status      = stat_q;
   assign done        = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         stat_q  <= ST_IDLE;
         final_q <= ST_BUSY;
         blk_q   <= 8'd1;
         txb_q   <= C_NAK;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else if (start) begin
         phase   <= PH_TX;
         stat_q  <= ST_BUSY;
         final_q <= ST_BUSY;
         blk_q   <= 8'd1;
         txb_q   <= C_NAK;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (rx_overrun && phase != PH_IDLE) begin
            phase  <= PH_IDLE;
            stat_q <= ST_ABT_OVR;
            done_q <= 1'b1;
         end else begin
            case (phase)
               PH_TX: if (tx_ready) begin
                  if (final_q == ST_BUSY) phase <= PH_HDR;
                  else begin
                     phase  <= PH_IDLE;
                     stat_q <= final_q;
                     done_q <= 1'b1;
                  end
               end
               PH_HDR: if (accept) begin
                  if (rx_data == C_SOH) phase <= PH_BNUM;
                  else if (rx_data == C_EOT) begin
                     phase   <= PH_TX;
                     txb_q   <= C_ACK;
                     final_q <= ST_DONE;
                  end else begin
                     phase  <= PH_IDLE;
                     stat_q <= ST_ABT_FRAME;
                     done_q <= 1'b1;
                  end
               end
               PH_BNUM: if (accept) begin
                  if (rx_data == blk_q) phase <= PH_BCPL;
                  else begin
                     phase  <= PH_IDLE;
                     stat_q <= ST_ABT_FRAME;
                     done_q <= 1'b1;
                  end
               end
               PH_BCPL: if (accept) begin
                  if (rx_data == ~blk_q) begin
                     phase <= PH_DATA;
                     cnt_q <= '0;
                  end else begin
                     phase  <= PH_IDLE;
                     stat_q <= ST_ABT_FRAME;
                     done_q <= 1'b1;
                  end
               end
               PH_DATA: if (accept) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == LAST_IDX) phase <= PH_CSUM;
               end
               PH_CSUM: if (accept) begin
                  phase <= PH_TX;
                  if (sum_ok) begin
                     txb_q   <= C_ACK;
                     blk_q   <= blk_q + 8'd1;
                     final_q <= ST_BUSY;
                  end else begin
                     txb_q   <= C_NAK;
                     final_q <= retry_last ? ST_ABT_RETRY : ST_BUSY;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/xmdm_block_rx.sv
`timescale 1ns/1ps
module xmdm_block_rx #(
   parameter int AW        = 16,
   parameter int BASE_ADDR = 'h8000,
   parameter int BLK_LEN   = 128,
   parameter int MAX_BAD   = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   output logic          rx_ready,
   input  logic          rx_overrun,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   input  logic          tx_ready,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic [2:0]    status,
   output logic          done
);
   generate
      if (BLK_LEN < 2) begin : g_bad_len
         $error("BLK_LEN must be at least 2");
      end
      if (MAX_BAD < 1) begin : g_bad_retry
         $error("MAX_BAD must be at least 1");
      end
      if (AW < 8 || AW > 31) begin : g_bad_aw
         $error("AW out of range");
      end
   endgenerate

   logic [7:0] sum;
   logic       sum_clr, addr_load, addr_rewind, bad_clr, bad_inc, retry_last;

   xmdm_ctrl #(.BLK_LEN(BLK_LEN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_overrun(rx_overrun),
      .tx_ready(tx_ready), .sum(sum), .retry_last(retry_last),
      .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .wr_en(wr_en), .sum_clr(sum_clr), .addr_load(addr_load),
      .addr_rewind(addr_rewind), .bad_clr(bad_clr), .bad_inc(bad_inc),
      .status(status), .done(done)
   );

   xmdm_sum #(.DW(8)) u_sum (
      .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add(wr_en),
      .din(rx_data), .sum(sum)
   );

   xmdm_addr #(.AW(AW), .BASE_ADDR(BASE_ADDR), .BLK_LEN(BLK_LEN)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(addr_load), .inc(wr_en),
      .rewind(addr_rewind), .addr(wr_addr)
   );

   xmdm_retry #(.MAX_BAD(MAX_BAD)) u_retry (
      .clk(clk), .rst_n(rst_n), .clr(bad_clr), .inc(bad_inc), .last(retry_last)
   );

   assign wr_data = rx_data;
endmodule

// File: rtl/xmdm_chk.sv
`timescale 1ns/1ps
module xmdm_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          rx_valid,
   input logic          rx_ready,
   input logic          rx_overrun,
   input logic          tx_valid,
   input logic          tx_ready,
   input logic [7:0]    tx_data,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [2:0]    status,
   input logic          done
);
   logic [AW-1:0] last_addr;
   logic          seen_wr;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_addr <= '0;
         seen_wr   <= 1'b0;
      end else if (start) begin
         seen_wr <= 1'b0;
      end else if (wr_en) begin
         last_addr <= wr_addr;
         seen_wr   <= 1'b1;
      end
   end

   p_start_nak_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> tx_valid && tx_data == 8'h15 && status == 3'd1);

   p_write_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> rx_valid && rx_ready);

   p_write_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && seen_wr && !start && (wr_addr != last_addr + 1'b1) |->
         (last_addr - wr_addr) == AW'(127));

   p_ovr_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun && status == 3'd1 && !start |=> status == 3'd5 && done);

   p_ovr_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> !wr_en);

   p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !start && !rx_overrun |=> tx_valid && $stable(tx_data));

   p_tx_blocks_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !rx_ready);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> status >= 3'd2 && status <= 3'd5);
endmodule

bind xmdm_block_rx xmdm_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid),
   .rx_ready(rx_ready), .rx_overrun(rx_overrun), .tx_valid(tx_valid),
   .tx_ready(tx_ready), .tx_data(tx_data), .wr_en(wr_en), .wr_addr(wr_addr),
   .status(status), .done(done)
);

// File: tb/xmdm_block_rx_test.sv
`timescale 1ns/1ps
module xmdm_block_rx_test;
   localparam int AW = 16;
   localparam int BASE = 'h8000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, rx_valid = 1'b0, rx_overrun = 1'b0, tx_ready = 1'b1;
   logic [7:0] rx_data = 8'h00;
   logic rx_ready, tx_valid, wr_en, done;
   logic [7:0] tx_data, wr_data;
   logic [AW-1:0] wr_addr;
   logic [2:0] status;

   int n_chk = 0, n_err = 0, done_cnt = 0;
   string cur_req = "R1";
   int unsigned exp_q[$];
   logic [AW-1:0] exp_addr;

   always #10 clk = ~clk;

   xmdm_block_rx uut (
      .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .status(status), .done(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: samples 5 ns before each rising edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (rst_n) begin
            if (done) done_cnt++;
            if (tx_valid && tx_ready) begin
               int unsigned got;
               got = 32'h0100_0000 | tx_data;
               if (exp_q.size() == 0) check(0, cur_req, got, 0);
               else begin
                  int unsigned e;
                  e = exp_q.pop_front();
                  check(got == e, cur_req, got, e);
               end
            end
            if (wr_en) begin
               int unsigned got;
               got = 32'h0200_0000 | (int'(wr_addr) << 8) | wr_data;
               if (exp_q.size() == 0) check(0, cur_req, got, 0);
               else begin
                  int unsigned e;
                  e = exp_q.pop_front();
                  check(got == e, cur_req, got, e);
               end
            end
         end
      end
   end

   task automatic exp_tx(input logic [7:0] b);
      exp_q.push_back(32'h0100_0000 | b);
   endtask

   task automatic exp_wr(input logic [7:0] b);
      exp_q.push_back(32'h0200_0000 | (int'(exp_addr) << 8) | b);
      exp_addr = exp_addr + 1'b1;
   endtask

   task automatic put_byte(input logic [7:0] b);
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic begin_xfer();
      exp_tx(8'h15);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      exp_addr = AW'(BASE);
      done_cnt = 0;
   endtask

   // bad_sum: corrupt checksum; last_nak_abort unused for expectation here
   task automatic send_frame(input logic [7:0] blk, input logic [7:0] seed, input bit bad_sum);
      logic [7:0] s;
      s = 8'h00;
      put_byte(8'h01);
      put_byte(blk);
      put_byte(~blk);
      for (int i = 0; i < 128; i++) begin
         logic [7:0] d;
         d = seed + 8'(i * 7);
         s = s + d;
         exp_wr(d);
         put_byte(d);
      end
      if (bad_sum) begin
         exp_addr = exp_addr - AW'(128);
         exp_tx(8'h15);
         put_byte(s ^ 8'h5A);
      end else begin
         exp_tx(8'h06);
         put_byte(s);
      end
   endtask

   task automatic drain(input string req);
      for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   task automatic wait_final(input int code, input string req);
      for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      drain(req);
      check(int'(status) == code, req, status, code);
      check(done_cnt == 1, req, done_cnt, 1);
   endtask

   initial begin
      #(20 * 190000);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(status == 3'd0 && !tx_valid && !rx_ready && !done && !wr_en, "R1", status, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R4 R5: two good frames then EOT
      cur_req = "R5";
      begin_xfer();
      @(negedge clk);
      check(status == 3'd1, "R1", status, 1);
      send_frame(8'd1, 8'h10, 1'b0);
      send_frame(8'd2, 8'hA3, 1'b0);
      cur_req = "R2";
      exp_tx(8'h06);
      put_byte(8'h04);
      wait_final(2, "R2");

      // R6: bad checksum then good resend to same addresses
      cur_req = "R6";
      begin_xfer();
      send_frame(8'd1, 8'h33, 1'b1);
      send_frame(8'd1, 8'h33, 1'b0);
      send_frame(8'd2, 8'h44, 1'b0);
      exp_tx(8'h06);
      put_byte(8'h04);
      wait_final(2, "R6");

      // R7: nine bad frames -> retry abort
      cur_req = "R7";
      begin_xfer();
      for (int k = 0; k < 9; k++) send_frame(8'd1, 8'(k), 1'b1);
      wait_final(3, "R7");

      // R7 count clears after a good frame: 8 bad, good, 8 bad, good, EOT
      cur_req = "R7";
      begin_xfer();
      for (int k = 0; k < 8; k++) send_frame(8'd1, 8'h20, 1'b1);
      send_frame(8'd1, 8'h20, 1'b0);
      for (int k = 0; k < 8; k++) send_frame(8'd2, 8'h21, 1'b1);
      send_frame(8'd2, 8'h21, 1'b0);
      exp_tx(8'h06);
      put_byte(8'h04);
      wait_final(2, "R7");

      // R3: wrong block number, wrong complement, wrong header
      cur_req = "R3";
      begin_xfer();
      put_byte(8'h01); put_byte(8'h02);
      wait_final(4, "R3");
      begin_xfer();
      put_byte(8'h01); put_byte(8'h01); put_byte(8'h01);
      wait_final(4, "R3");
      begin_xfer();
      put_byte(8'h02);
      wait_final(4, "R3");

      // R8: overrun mid-payload, same cycle as an offered byte
      cur_req = "R8";
      begin_xfer();
      put_byte(8'h01); put_byte(8'h01); put_byte(8'hFE);
      for (int i = 0; i < 5; i++) begin
         exp_wr(8'(i));
         put_byte(8'(i));
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'hEE; rx_overrun = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rx_overrun = 1'b0;
      check(status == 3'd5, "R8", status, 5);
      check(!rx_ready, "R8", rx_ready, 0);
      wait_final(5, "R8");

      // R9: handshake held while transmitter not ready
      cur_req = "R9";
      tx_ready = 1'b0;
      begin_xfer();
      repeat (5) @(negedge clk);
      check(tx_valid && tx_data == 8'h15 && !rx_ready, "R9", {tx_valid, tx_data}, 9'h115);
      tx_ready = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(rx_ready && !tx_valid, "R9", {rx_ready, tx_valid}, 2'b10);
      drain("R9");

      // R12: restart during a frame, then block 1 again at base
      cur_req = "R12";
      put_byte(8'h01); put_byte(8'h01); put_byte(8'hFE);
      for (int i = 0; i < 10; i++) begin
         exp_wr(8'hC0 + 8'(i));
         put_byte(8'hC0 + 8'(i));
      end
      begin_xfer();
      check(status == 3'd1, "R12", status, 1);
      send_frame(8'd1, 8'h77, 1'b0);
      exp_tx(8'h06);
      put_byte(8'h04);
      wait_final(2, "R12");

      // R11: block number wraps 255 -> 0
      cur_req = "R11";
      begin_xfer();
      for (int n = 1; n <= 256; n++) send_frame(8'(n), 8'(n * 3), 1'b0);
      exp_tx(8'h06);
      put_byte(8'h04);
      wait_final(2, "R11");

      // R10: status held, no further done after final
      repeat (5) @(negedge clk);
      check(done_cnt == 1 && status == 3'd2, "R10", done_cnt, 1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule